// File: doc/BRIEF.md
# Register Rename Table with Branch Checkpoints

This block translates architectural register names into physical register numbers for an out-of-order core. For each decoded instruction it returns the physical registers that hold the newest values of two source operands. When the instruction writes a destination, it takes a fresh physical register from a free-register bit vector and reports the physical register that held that name before. Because every write gets a new register, write-after-read and write-after-write hazards disappear. True data dependencies remain, because a later reader still sees the newest mapping.

When a predicted branch is renamed, the block copies the whole map and free vector into one of a small number of snapshot slots. On a misprediction it restores that copy in a single cycle. Any physical register handed out after the branch becomes free again. The snapshot slot and every younger slot are released. A correctly predicted branch only gives back its slot. At commit, the retiring instruction's old physical register is returned to the live free vector. The same register is also marked free in every stored snapshot, so that a later restore cannot lose it. Renaming stalls through a ready/valid handshake when no physical register is free or when all snapshot slots are taken.

Top module: `rename_map_ckpt`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers 32 to 63 are free, every snapshot slot is idle and renReady is 1.
- R2: physSrcA and physSrcB give, in the same cycle, the current mapping of renSrcA and renSrcB, including every rename accepted in earlier cycles.
- R3: An accepted instruction with renDstWr=1 and a non-zero renDst receives the lowest-numbered free physical register on physDst. The previous mapping appears on prevPhys, and later instructions see the new mapping.
- R4: Architectural register 0 always maps to physical 0 and is never renamed. An instruction with renDst=0 or renDstWr=0 reports physDst=0 and prevPhys=0 and leaves the free vector unchanged.
- R5: With no free physical register, renReady is 0 for an instruction that needs a destination. It stays 1 for one that does not.
- R6: An accepted instruction with renIsBranch=1 takes the lowest-numbered idle snapshot slot and reports it on ckptTag. The snapshot holds the map and free vector as they stood before that instruction's own allocation.
- R7: With all four slots in use, renReady is 0 for a branch.
- R8: resolveValid=1 with resolveMiss=1 restores the map and free vector of slot resolveTag at the next edge. It releases that slot and every slot taken after it. renReady is 0 during that cycle.
- R9: resolveValid=1 with resolveMiss=0 releases slot resolveTag only and leaves the map unchanged.
- R10: commitValid=1 frees physical register commitPhys in the live free vector and in every stored snapshot, including one restored in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | An instruction is offered for rename |
| renReady | output | 1 | The offered instruction is accepted this cycle |
| renSrcA | input | 5 | First source architectural register |
| renSrcB | input | 5 | Second source architectural register |
| renDst | input | 5 | Destination architectural register |
| renDstWr | input | 1 | The instruction writes renDst |
| renIsBranch | input | 1 | The instruction is a predicted branch needing a snapshot |
| physSrcA | output | 6 | Physical register for renSrcA |
| physSrcB | output | 6 | Physical register for renSrcB |
| physDst | output | 6 | Newly allocated physical destination, 0 if none |
| prevPhys | output | 6 | Physical register previously mapped to renDst, 0 if none |
| ckptTag | output | 2 | Snapshot slot given to an accepted branch |
| resolveValid | input | 1 | A branch resolves this cycle |
| resolveMiss | input | 1 | The resolving branch was mispredicted |
| resolveTag | input | 2 | Snapshot slot of the resolving branch |
| commitValid | input | 1 | An instruction commits this cycle |
| commitPhys | input | 6 | Old physical register to free at commit |

## Verification
The assertions check several properties on every cycle. Physical register 0 stays mapped to architectural register 0. An allocation always comes from a free register and removes it from the free vector. Commits free their register in the live vector and in every snapshot. Slots become busy when taken and idle when resolved, and no rename is accepted during a recovery. Only the bench's scenarios can show the values that come back after a misprediction. These are the restored source mappings, the reuse of registers freed while the branch was in flight, and the release of younger slots. Only the bench can also show the lowest-first allocation order across a full drain of the free list.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int ARCH_REGS  = 32;
  localparam int PHYS_REGS  = 64;
  localparam int CKPT_SLOTS = 4;

  // Strobes from control to datapath, all valid for the current cycle.
  typedef struct packed {
    logic                  doAlloc;
    logic                  doCkpt;
    logic [CKPT_SLOTS-1:0] ckptSel;
    logic                  doRestore;
    logic [CKPT_SLOTS-1:0] restoreSel;
  } renStrobes_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int ARCH_N = rename_pkg::ARCH_REGS,
  parameter int SLOT_N = rename_pkg::CKPT_SLOTS,
  localparam int AW = $clog2(ARCH_N),
  localparam int TW = $clog2(SLOT_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          renValid,
  input  logic [AW-1:0] renDst,
  input  logic          renDstWr,
  input  logic          renIsBranch,
  input  logic          resolveValid,
  input  logic          resolveMiss,
  input  logic [TW-1:0] resolveTag,
  input  logic          freeEmpty,
  output logic          renReady,
  output logic [TW-1:0] ckptTag,
  output renStrobes_t   strobes
);

  logic [SLOT_N-1:0] busy;
  logic [SLOT_N-1:0] olderMask [SLOT_N];
  logic [SLOT_N-1:0] ckptOneHot, resolveOneHot, younger, relMask, busyNext;
  logic [TW-1:0]     freeSlot;
  logic              needAlloc, recovering, fire;

  // Lowest idle snapshot slot.
  always_comb begin
    freeSlot = '0;
    for (int k = SLOT_N - 1; k >= 0; k--) begin
      if (!busy[k]) freeSlot = TW'(k);
    end
  end

  always_comb begin
    ckptOneHot = '0;
    ckptOneHot[freeSlot] = 1'b1;
    resolveOneHot = '0;
    resolveOneHot[resolveTag] = 1'b1;
  end

  // Slots taken after the resolving branch record it in their older mask.
  always_comb begin
    for (int k = 0; k < SLOT_N; k++) begin
      younger[k] = busy[k] && olderMask[k][resolveTag];
    end
  end

  assign needAlloc  = renDstWr && (renDst != '0);
  assign recovering = resolveValid && resolveMiss;
  assign renReady   = !recovering && !(needAlloc && freeEmpty) && !(renIsBranch && (&busy));
  assign fire       = renValid && renReady;
  assign ckptTag    = freeSlot;

  always_comb begin
    relMask = '0;
    if (resolveValid) relMask = resolveMiss ? (resolveOneHot | younger) : resolveOneHot;
  end

  always_comb begin
    strobes.doAlloc    = fire && needAlloc;
    strobes.doCkpt     = fire && renIsBranch;
    strobes.ckptSel    = ckptOneHot;
    strobes.doRestore  = recovering;
    strobes.restoreSel = resolveOneHot;
  end

  assign busyNext = (busy & ~relMask) | (strobes.doCkpt ? ckptOneHot : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      for (int k = 0; k < SLOT_N; k++) olderMask[k] <= '0;
    end else begin
      busy <= busyNext;
      for (int k = 0; k < SLOT_N; k++) begin
        if (strobes.doCkpt && ckptOneHot[k]) olderMask[k] <= busy & ~relMask;
        else                                 olderMask[k] <= olderMask[k] & ~relMask;
      end
    end
  end

  // R6: a slot handed to a branch is busy afterwards.
  p_ckpt_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.doCkpt |=> busy[$past(freeSlot)]);

  // R7: no branch is accepted while every slot is busy.
  p_branch_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (renValid && renIsBranch && (&busy)) |-> !fire);

  // R8: a mispredicted slot is idle afterwards, and nothing renames meanwhile.
  p_miss_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |=> !busy[$past(resolveTag)]);
  p_no_rename_in_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> !fire);

  // R9: a correctly resolved slot is idle afterwards.
  p_hit_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resolveValid && !resolveMiss) |=> !busy[$past(resolveTag)]);
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int ARCH_N = rename_pkg::ARCH_REGS,
  parameter int PHYS_N = rename_pkg::PHYS_REGS,
  parameter int SLOT_N = rename_pkg::CKPT_SLOTS,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  renStrobes_t   strobes,
  input  logic [AW-1:0] renSrcA,
  input  logic [AW-1:0] renSrcB,
  input  logic [AW-1:0] renDst,
  input  logic          commitValid,
  input  logic [PW-1:0] commitPhys,
  output logic [PW-1:0] physSrcA,
  output logic [PW-1:0] physSrcB,
  output logic [PW-1:0] physDst,
  output logic [PW-1:0] prevPhys,
  output logic          freeEmpty
);

  logic [PW-1:0]     mapTbl     [ARCH_N];
  logic [PW-1:0]     ckptMap    [SLOT_N][ARCH_N];
  logic [PW-1:0]     restoreMap [ARCH_N];
  logic [PHYS_N-1:0] freeVec;
  logic [PHYS_N-1:0] ckptFree   [SLOT_N];
  logic [PHYS_N-1:0] restoreFree, commitMask, allocMask;
  logic [PW-1:0]     allocIdx;

  // Lowest-numbered free physical register.
  always_comb begin
    allocIdx = '0;
    for (int i = PHYS_N - 1; i >= 0; i--) begin
      if (freeVec[i]) allocIdx = PW'(i);
    end
  end

  always_comb begin
    commitMask = '0;
    if (commitValid) commitMask[commitPhys] = 1'b1;
    allocMask = '0;
    if (strobes.doAlloc) allocMask[allocIdx] = 1'b1;
  end

  always_comb begin
    restoreMap  = ckptMap[0];
    restoreFree = ckptFree[0];
    for (int k = 1; k < SLOT_N; k++) begin
      if (strobes.restoreSel[k]) begin
        restoreMap  = ckptMap[k];
        restoreFree = ckptFree[k];
      end
    end
  end

  assign freeEmpty = ~|freeVec;
  assign physSrcA  = mapTbl[renSrcA];
  assign physSrcB  = mapTbl[renSrcB];
  assign physDst   = strobes.doAlloc ? allocIdx : '0;
  assign prevPhys  = strobes.doAlloc ? mapTbl[renDst] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_N; i++) mapTbl[i] <= PW'(i);
      for (int i = 0; i < PHYS_N; i++) freeVec[i] <= (i >= ARCH_N);
      for (int k = 0; k < SLOT_N; k++) begin
        ckptFree[k] <= '0;
        for (int i = 0; i < ARCH_N; i++) ckptMap[k][i] <= '0;
      end
    end else begin
      if (strobes.doRestore) begin
        mapTbl  <= restoreMap;
        freeVec <= restoreFree | commitMask;
      end else begin
        if (strobes.doAlloc) mapTbl[renDst] <= allocIdx;
        freeVec <= (freeVec & ~allocMask) | commitMask;
      end
      for (int k = 0; k < SLOT_N; k++) begin
        if (strobes.doCkpt && strobes.ckptSel[k]) begin
          ckptMap[k]  <= mapTbl;
          ckptFree[k] <= freeVec | commitMask;
        end else begin
          ckptFree[k] <= ckptFree[k] | commitMask;
        end
      end
    end
  end

  // R4: physical 0 stays bound to architectural 0.
  p_zero_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mapTbl[0] == '0);

  // R3: allocation draws from a free register and consumes it.
  p_alloc_from_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.doAlloc |-> (freeVec[allocIdx] && !freeEmpty));
  p_alloc_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.doAlloc && !strobes.doRestore) |=>
      (!freeVec[$past(allocIdx)] && mapTbl[$past(renDst)] == $past(allocIdx)));

  // R10: a committed register is free in the live vector and every snapshot.
  p_commit_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commitValid |=> freeVec[$past(commitPhys)]);
  for (genvar g = 0; g < SLOT_N; g++) begin : g_ckptChk
    p_commit_ckpt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      commitValid |=> ckptFree[g][$past(commitPhys)]);
  end
endmodule

// File: rtl/rename_map_ckpt.sv
module rename_map_ckpt
  import rename_pkg::*;
#(
  parameter int ARCH_N = rename_pkg::ARCH_REGS,
  parameter int PHYS_N = rename_pkg::PHYS_REGS,
  parameter int SLOT_N = rename_pkg::CKPT_SLOTS,
  localparam int AW = $clog2(ARCH_N),
  localparam int PW = $clog2(PHYS_N),
  localparam int TW = $clog2(SLOT_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          renValid,
  output logic          renReady,
  input  logic [AW-1:0] renSrcA,
  input  logic [AW-1:0] renSrcB,
  input  logic [AW-1:0] renDst,
  input  logic          renDstWr,
  input  logic          renIsBranch,
  output logic [PW-1:0] physSrcA,
  output logic [PW-1:0] physSrcB,
  output logic [PW-1:0] physDst,
  output logic [PW-1:0] prevPhys,
  output logic [TW-1:0] ckptTag,
  input  logic          resolveValid,
  input  logic          resolveMiss,
  input  logic [TW-1:0] resolveTag,
  input  logic          commitValid,
  input  logic [PW-1:0] commitPhys
);

  renStrobes_t strobes;
  logic        freeEmpty;

  rename_ctrl #(.ARCH_N(ARCH_N), .SLOT_N(SLOT_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renDst(renDst),
    .renDstWr(renDstWr), .renIsBranch(renIsBranch), .resolveValid(resolveValid),
    .resolveMiss(resolveMiss), .resolveTag(resolveTag), .freeEmpty(freeEmpty),
    .renReady(renReady), .ckptTag(ckptTag), .strobes(strobes)
  );

  rename_datapath #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .SLOT_N(SLOT_N)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .renSrcA(renSrcA),
    .renSrcB(renSrcB), .renDst(renDst), .commitValid(commitValid),
    .commitPhys(commitPhys), .physSrcA(physSrcA), .physSrcB(physSrcB),
    .physDst(physDst), .prevPhys(prevPhys), .freeEmpty(freeEmpty)
  );
endmodule

// File: tb/rename_map_ckpt_test.sv
module rename_map_ckpt_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       renValid, renReady, renDstWr, renIsBranch;
  logic [4:0] renSrcA, renSrcB, renDst;
  logic [5:0] physSrcA, physSrcB, physDst, prevPhys, commitPhys;
  logic [1:0] ckptTag, resolveTag;
  logic       resolveValid, resolveMiss, commitValid;
  int         checks = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  rename_map_ckpt uut (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renReady(renReady),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst), .renDstWr(renDstWr),
    .renIsBranch(renIsBranch), .physSrcA(physSrcA), .physSrcB(physSrcB),
    .physDst(physDst), .prevPhys(prevPhys), .ckptTag(ckptTag),
    .resolveValid(resolveValid), .resolveMiss(resolveMiss), .resolveTag(resolveTag),
    .commitValid(commitValid), .commitPhys(commitPhys)
  );

  typedef struct packed {
    logic [4:0] a, b, d;
    logic       wr;
    logic [5:0] ea, eb, ed, ep;
  } vec_t;

  // Rename sequence from reset: sources, destination, write flag, expected outputs.
  localparam vec_t VECS [6] = '{
    '{5'd1,  5'd2, 5'd3,  1'b1, 6'd1,  6'd2,  6'd32, 6'd3 },
    '{5'd3,  5'd0, 5'd3,  1'b1, 6'd32, 6'd0,  6'd33, 6'd32},
    '{5'd3,  5'd5, 5'd0,  1'b1, 6'd33, 6'd5,  6'd0,  6'd0 },
    '{5'd4,  5'd3, 5'd4,  1'b0, 6'd4,  6'd33, 6'd0,  6'd0 },
    '{5'd4,  5'd4, 5'd4,  1'b1, 6'd4,  6'd4,  6'd34, 6'd4 },
    '{5'd31, 5'd4, 5'd31, 1'b1, 6'd31, 6'd34, 6'd35, 6'd31}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    renValid = 0; renDstWr = 0; renIsBranch = 0;
    renSrcA = 0; renSrcB = 0; renDst = 0;
    resolveValid = 0; resolveMiss = 0; resolveTag = 0;
    commitValid = 0; commitPhys = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic doReset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // Offer a rename at the current negedge and settle the outputs.
  task automatic offer(input int a, input int b, input int d, input logic wr, input logic br);
    renValid = 1; renSrcA = 5'(a); renSrcB = 5'(b); renDst = 5'(d);
    renDstWr = wr; renIsBranch = br;
    #1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1: reset state
    renSrcA = 10; renSrcB = 31; #1;
    chk("R1", "ready", renReady, 1);
    chk("R1", "srcA map", physSrcA, 10);
    chk("R1", "srcB map", physSrcB, 31);
    idle();

    // R2 R3 R4: vector table
    for (int v = 0; v < 6; v++) begin
      offer(VECS[v].a, VECS[v].b, VECS[v].d, VECS[v].wr, 1'b0);
      chk("R2", "physSrcA", physSrcA, VECS[v].ea);
      chk("R2", "physSrcB", physSrcB, VECS[v].eb);
      chk(VECS[v].ed == 0 ? "R4" : "R3", "physDst", physDst, VECS[v].ed);
      chk(VECS[v].ed == 0 ? "R4" : "R3", "prevPhys", prevPhys, VECS[v].ep);
      tick();
    end

    // R10: committed register is reused first
    commitValid = 1; commitPhys = 3; #1; tick();
    offer(0, 0, 5, 1, 0);
    chk("R10", "reuse freed", physDst, 3);
    chk("R3", "prev of r5", prevPhys, 5);
    tick();

    // R6: first branch gets slot 0, sees newest map
    offer(5, 0, 0, 0, 1);
    chk("R2", "branch src", physSrcA, 3);
    chk("R6", "first tag", ckptTag, 0);
    tick();
    offer(0, 0, 6, 1, 0); chk("R3", "spec alloc r6", physDst, 36); tick();
    offer(0, 0, 5, 1, 0); chk("R3", "spec alloc r5", physDst, 37);
    chk("R3", "spec prev r5", prevPhys, 3); tick();
    offer(0, 0, 0, 0, 1); chk("R6", "second tag", ckptTag, 1); tick();
    offer(0, 0, 7, 1, 0); chk("R3", "spec alloc r7", physDst, 38); tick();
    commitValid = 1; commitPhys = 32; #1; tick();

    // R8: mispredict slot 0 blocks rename, then restores
    resolveValid = 1; resolveMiss = 1; resolveTag = 0;
    offer(0, 0, 9, 1, 0);
    chk("R8", "ready during miss", renReady, 0);
    tick();
    renSrcA = 5; renSrcB = 6; #1;
    chk("R8", "restored r5", physSrcA, 3);
    chk("R8", "restored r6", physSrcB, 6);
    renSrcA = 7; #1;
    chk("R8", "restored r7", physSrcA, 7);
    idle();
    offer(0, 0, 6, 1, 0);
    chk("R10", "commit kept in snapshot", physDst, 32);
    chk("R8", "prev after restore", prevPhys, 6);
    tick();

    // R8 R6: younger slot 1 was released too
    for (int t = 0; t < 4; t++) begin
      offer(0, 0, 0, 0, 1);
      chk("R8", "slot order", ckptTag, t);
      tick();
    end
    // R7: all slots busy
    offer(0, 0, 0, 0, 1);
    chk("R7", "branch stalls", renReady, 0);
    renIsBranch = 0; renDstWr = 1; renDst = 9; #1;
    chk("R7", "non-branch ready", renReady, 1);
    renValid = 0; #1;
    tick();

    // R9: correct resolve of slot 2
    resolveValid = 1; resolveMiss = 0; resolveTag = 2; #1; tick();
    renSrcA = 6; #1;
    chk("R9", "map unchanged", physSrcA, 32);
    idle();
    offer(0, 0, 0, 0, 1);
    chk("R9", "slot reused", ckptTag, 2);
    tick();

    // R5: drain free list after fresh reset
    doReset();
    #1;
    chk("R1", "ready after reset", renReady, 1);
    for (int i = 0; i < 32; i++) begin
      offer(0, 0, 1, 1, 0);
      chk("R3", "drain order", physDst, 32 + i);
      tick();
    end
    offer(0, 0, 1, 1, 0);
    chk("R5", "stall when empty", renReady, 0);
    renDstWr = 0; #1;
    chk("R5", "no-dest proceeds", renReady, 1);
    tick();
    commitValid = 1; commitPhys = 40; #1; tick();
    offer(0, 0, 2, 1, 0);
    chk("R5", "ready after free", renReady, 1);
    chk("R10", "freed reg given", physDst, 40);
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule